// File: doc/BRIEF.md
# Fuse Array Control Register Block

This block sits between a 32-bit register bus and a one-time-programmable fuse array. It keeps a shadow copy of every fuse word for fast reads and refills the shadows from the array on request. It accepts program requests only after a fresh unlock key, and it enforces per-word read and write locks that come from static input vectors. Busy and a sticky error flag are reported in the control register. The fuse burning itself is carried out by a separate programming engine, which receives the latched address and data.

Software programs the timing word and loads the data lanes. It then writes the control register with the unlock key and the group address, and writes data lane 0 last to launch. Completion is found by polling busy. Afterwards a shadow reload is started through the set alias, and the new contents are read from the shadow window.

Top module: `fuse_ctl_regs`

## Requirements
- R1: After reset, the control register (0x000) reads 0, every shadow word reads 0, `prog_req_o` and `fuse_rd_en_o` are low and `req_ready_o` is high.
- R2: A launch is armed only while control bits [31:16] hold 0x3E77. Any other key leaves a data-lane-0 write with no program effect, and the key field reads back as written. A launch attempt clears the key field to 0.
- R3: A lane-0 write (0x020) while armed, with busy and error both clear, raises `prog_req_o` and control bit 8 (busy). It latches control bits [7:0] onto `prog_addr_o`. Later address writes do not move `prog_addr_o`, and busy drops in the cycle after `prog_done_i`.
- R4: While busy, writes to the data lanes are ignored and `prog_data_o` stays constant.
- R5: A group spans `BANK_WORDS` consecutive words (word = address·BANK_WORDS + k). Lane k sits at 0x020 + 0x10·k and drives `prog_data_o[32k +: 32]`. Only the write to lane 0 starts a program.
- R6: A launch aimed at a group that holds a write-locked word, or a word past `NUM_WORDS`, raises no `prog_req_o` and no busy. It sets control bit 9 (error).
- R7: Shadow word n reads at 0x400 + 0x10·n. A read-locked word returns 0xBADABADA and sets error.
- R8: Error is sticky. While it is set, shadow reads return 0xBADABADA with no other effect, and shadow writes, reloads and launches are dropped. Writing bit 9 to the clear alias (0x008) clears it.
- R9: Writing bit 10 to the set alias (0x004) while idle and error-free starts a reload. The reload reads every word once through the fuse read port and copies it into the shadows. Control bits 10 and 8 read 1 until the copy ends, and then clear by themselves.
- R10: A shadow write updates the word unless the word is write-locked or a reload is running. In those cases error is set and the word keeps its old value.
- R11: Bits [7:0] written to the set alias are ORed into the address field, and bits [7:0] written to the clear alias are removed from it.
- R12: The timing register (0x010) reads back its last written value and drives `timing_o`.
- R13: Every accepted request gets exactly one `rsp_valid_o` pulse in the next cycle. `req_ready_o` is low while `rsp_valid_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Bus request valid |
| req_ready_o | output | 1 | Bus request ready |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 12 | Byte offset |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Response valid |
| rsp_rdata_o | output | 32 | Read data |
| rd_lock_i | input | NUM_WORDS | Per-word read lock |
| wr_lock_i | input | NUM_WORDS | Per-word write lock |
| timing_o | output | 32 | Timing word to the engine |
| prog_req_o | output | 1 | Program request, held until done |
| prog_addr_o | output | 8 | Latched group address |
| prog_data_o | output | 32·BANK_WORDS | Program data lanes |
| prog_done_i | input | 1 | Engine completion pulse |
| fuse_rd_en_o | output | 1 | Fuse array read strobe |
| fuse_rd_addr_o | output | IDX_W | Fuse word index |
| fuse_rd_data_i | input | 32 | Fuse word, one cycle after strobe |

## Verification
The bench uses 16 words in groups of four, with one read-locked word and two write-locked words that share a group. Every shadow word is swept after a reload, after a write pass and after programming, and the expected fuse image is computed from initial values ORed with the lane patterns. Every group address, including one past the end, is launched: the free groups separate correct lane order and address latching, the locked group tests rejection, and the out-of-range group tests the bound check. A wrong key, writes made while busy or in error, and writes during a reload separate the guarded paths from the plain register updates.

// File: rtl/fuse_ctl_pkg.sv
package fuse_ctl_pkg;
  localparam logic [15:0] UNLOCK_KEY = 16'h3E77;
  localparam logic [31:0] POISON     = 32'hBADA_BADA;
  localparam logic [11:0] OFF_CTRL   = 12'h000;
  localparam logic [11:0] OFF_SET    = 12'h004;
  localparam logic [11:0] OFF_CLR    = 12'h008;
  localparam logic [11:0] OFF_TIMING = 12'h010;
  localparam int BIT_BUSY   = 8;
  localparam int BIT_ERR    = 9;
  localparam int BIT_RELOAD = 10;
  localparam int DATA_REGS  = 4;
endpackage

// File: rtl/fuse_ctl_decode.sv
module fuse_ctl_decode #(
  parameter int NUM_WORDS = 16,
  parameter int IDX_W     = 4
) (
  input  logic [11:0]      addr_i,
  output logic             is_ctrl_o,
  output logic             is_set_o,
  output logic             is_clr_o,
  output logic             is_timing_o,
  output logic             is_data_o,
  output logic [1:0]       data_sel_o,
  output logic             is_shadow_o,
  output logic [IDX_W-1:0] shadow_idx_o
);
  import fuse_ctl_pkg::*;
  logic [2:0] lane;

  assign is_ctrl_o   = addr_i == OFF_CTRL;
  assign is_set_o    = addr_i == OFF_SET;
  assign is_clr_o    = addr_i == OFF_CLR;
  assign is_timing_o = addr_i == OFF_TIMING;

  assign lane        = addr_i[6:4] - 3'd2;
  assign is_data_o   = (addr_i[11:7] == 5'd0) && (addr_i[3:0] == 4'd0) &&
                       (addr_i[6:4] >= 3'd2) && (addr_i[6:4] <= 3'd5);
  assign data_sel_o  = lane[1:0];

  assign is_shadow_o  = (addr_i[11:10] == 2'b01) && (addr_i[3:0] == 4'd0) &&
                        (int'(addr_i[9:4]) < NUM_WORDS);
  assign shadow_idx_o = addr_i[4 +: IDX_W];
endmodule

// File: rtl/fuse_group_lock.sv
module fuse_group_lock #(
  parameter int NUM_WORDS  = 16,
  parameter int BANK_WORDS = 1
) (
  input  logic [7:0]           addr_i,
  input  logic [NUM_WORDS-1:0] wr_lock_i,
  output logic                 locked_o
);
  int w;
  always_comb begin
    locked_o = 1'b0;
    w = 0;
    for (int k = 0; k < BANK_WORDS; k++) begin
      w = int'(addr_i) * BANK_WORDS + k;
      if (w >= NUM_WORDS) locked_o = 1'b1;
      else if (wr_lock_i[w]) locked_o = 1'b1;
    end
  end
endmodule

// File: rtl/fuse_shadow_bank.sv
module fuse_shadow_bank #(
  parameter int NUM_WORDS = 16,
  parameter int IDX_W     = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reload_start_i,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [31:0]      wr_data_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [31:0]      rd_word_o,
  output logic             reloading_o,
  output logic             fuse_rd_en_o,
  output logic [IDX_W-1:0] fuse_rd_addr_o,
  input  logic [31:0]      fuse_rd_data_i
);
  localparam logic [IDX_W:0]   END_CNT  = (IDX_W+1)'(NUM_WORDS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WORDS - 1);

  logic [31:0]      mem_q [NUM_WORDS];
  logic             active_q, cap_q, issue;
  logic [IDX_W:0]   cnt_q;
  logic [IDX_W-1:0] cap_idx_q;

  assign issue          = active_q && (cnt_q < END_CNT);
  assign fuse_rd_en_o   = issue;
  assign fuse_rd_addr_o = cnt_q[IDX_W-1:0];
  assign reloading_o    = active_q;
  assign rd_word_o      = mem_q[rd_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q  <= 1'b0;
      cap_q     <= 1'b0;
      cnt_q     <= '0;
      cap_idx_q <= '0;
      for (int i = 0; i < NUM_WORDS; i++) mem_q[i] <= '0;
    end else begin
      if (reload_start_i && !active_q) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
      end else if (issue) begin
        cnt_q <= cnt_q + 1'b1;
      end
      cap_q     <= issue;
      cap_idx_q <= cnt_q[IDX_W-1:0];
      if (cap_q) begin
        mem_q[cap_idx_q] <= fuse_rd_data_i;
        if (cap_idx_q == LAST_IDX) active_q <= 1'b0;
      end else if (wr_en_i) begin
        mem_q[wr_idx_i] <= wr_data_i;
      end
    end
  end
endmodule

// File: rtl/fuse_ctl_regs.sv
module fuse_ctl_regs
  import fuse_ctl_pkg::*;
#(
  parameter int NUM_WORDS  = 16,
  parameter int BANK_WORDS = 1,
  localparam int IDX_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  localparam int PROG_W    = 32 * BANK_WORDS
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  output logic                 req_ready_o,
  input  logic                 req_we_i,
  input  logic [11:0]          req_addr_i,
  input  logic [31:0]          req_wdata_i,
  output logic                 rsp_valid_o,
  output logic [31:0]          rsp_rdata_o,
  input  logic [NUM_WORDS-1:0] rd_lock_i,
  input  logic [NUM_WORDS-1:0] wr_lock_i,
  output logic [31:0]          timing_o,
  output logic                 prog_req_o,
  output logic [7:0]           prog_addr_o,
  output logic [PROG_W-1:0]    prog_data_o,
  input  logic                 prog_done_i,
  output logic                 fuse_rd_en_o,
  output logic [IDX_W-1:0]     fuse_rd_addr_o,
  input  logic [31:0]          fuse_rd_data_i
);
  logic             acc, wr, rd, busy, armed, reloading, grp_locked;
  logic             dec_ctrl, dec_set, dec_clr, dec_timing, dec_data, dec_shadow;
  logic [1:0]       dec_sel;
  logic [IDX_W-1:0] dec_idx;
  logic [7:0]       addr_q, prog_addr_q;
  logic [15:0]      key_q;
  logic             err_q, prog_active_q, rsp_valid_q;
  logic [31:0]      timing_q, rsp_rdata_q, rd_val, shadow_word, ctrl_rd;
  logic [31:0]      data_q [DATA_REGS];
  logic             reload_start, shadow_we;

  fuse_ctl_decode #(.NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)) u_dec (
    .addr_i(req_addr_i), .is_ctrl_o(dec_ctrl), .is_set_o(dec_set), .is_clr_o(dec_clr),
    .is_timing_o(dec_timing), .is_data_o(dec_data), .data_sel_o(dec_sel),
    .is_shadow_o(dec_shadow), .shadow_idx_o(dec_idx)
  );

  fuse_group_lock #(.NUM_WORDS(NUM_WORDS), .BANK_WORDS(BANK_WORDS)) u_lock (
    .addr_i(addr_q), .wr_lock_i(wr_lock_i), .locked_o(grp_locked)
  );

  assign acc   = req_valid_i && req_ready_o;
  assign wr    = acc && req_we_i;
  assign rd    = acc && !req_we_i;
  assign busy  = prog_active_q || reloading;
  assign armed = key_q == UNLOCK_KEY;

  assign reload_start = wr && dec_set && req_wdata_i[BIT_RELOAD] && !busy && !err_q;
  assign shadow_we    = wr && dec_shadow && !reloading && !wr_lock_i[dec_idx] && !err_q;

  fuse_shadow_bank #(.NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)) u_shadow (
    .clk_i(clk_i), .rst_ni(rst_ni), .reload_start_i(reload_start),
    .wr_en_i(shadow_we), .wr_idx_i(dec_idx), .wr_data_i(req_wdata_i),
    .rd_idx_i(dec_idx), .rd_word_o(shadow_word), .reloading_o(reloading),
    .fuse_rd_en_o(fuse_rd_en_o), .fuse_rd_addr_o(fuse_rd_addr_o),
    .fuse_rd_data_i(fuse_rd_data_i)
  );

  assign ctrl_rd = {key_q, 5'd0, reloading, err_q, busy, addr_q};

  always_comb begin
    rd_val = '0;
    if (dec_ctrl || dec_set || dec_clr) rd_val = ctrl_rd;
    else if (dec_timing)                rd_val = timing_q;
    else if (dec_data)                  rd_val = data_q[dec_sel];
    else if (dec_shadow) begin
      if (err_q || rd_lock_i[dec_idx])  rd_val = POISON;
      else                              rd_val = shadow_word;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q        <= '0;
      key_q         <= '0;
      err_q         <= 1'b0;
      timing_q      <= '0;
      prog_active_q <= 1'b0;
      prog_addr_q   <= '0;
      rsp_valid_q   <= 1'b0;
      rsp_rdata_q   <= '0;
      for (int i = 0; i < DATA_REGS; i++) data_q[i] <= '0;
    end else begin
      rsp_valid_q <= acc;
      if (rd) rsp_rdata_q <= rd_val;
      if (prog_active_q && prog_done_i) prog_active_q <= 1'b0;
      if (wr) begin
        if (dec_ctrl) begin
          addr_q <= req_wdata_i[7:0];
          key_q  <= req_wdata_i[31:16];
        end
        if (dec_set) addr_q <= addr_q | req_wdata_i[7:0];
        if (dec_clr) begin
          addr_q <= addr_q & ~req_wdata_i[7:0];
          if (req_wdata_i[BIT_ERR]) err_q <= 1'b0;
        end
        if (dec_timing) timing_q <= req_wdata_i;
        if (dec_data && !busy) begin
          data_q[dec_sel] <= req_wdata_i;
          // lane 0 is the launch trigger
          if (dec_sel == 2'd0 && armed && !err_q) begin
            key_q <= '0;
            if (grp_locked) err_q <= 1'b1;
            else begin
              prog_active_q <= 1'b1;
              prog_addr_q   <= addr_q;
            end
          end
        end
        if (dec_shadow && (reloading || wr_lock_i[dec_idx])) err_q <= 1'b1;
      end
      if (rd && dec_shadow && !err_q && rd_lock_i[dec_idx]) err_q <= 1'b1;
    end
  end

  for (genvar k = 0; k < BANK_WORDS; k++) begin : g_lane
    assign prog_data_o[32*k +: 32] = data_q[k];
  end

  assign req_ready_o = !rsp_valid_q;
  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rsp_rdata_q;
  assign timing_o    = timing_q;
  assign prog_req_o  = prog_active_q;
  assign prog_addr_o = prog_addr_q;
endmodule

// File: rtl/fuse_ctl_regs_chk.sv
module fuse_ctl_regs_chk #(
  parameter int NUM_WORDS = 16,
  parameter int IDX_W     = 4,
  parameter int PROG_W    = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              req_we_i,
  input logic [11:0]       req_addr_i,
  input logic              clr_err_bit_i,
  input logic              rsp_valid_o,
  input logic              prog_req_o,
  input logic              prog_done_i,
  input logic [7:0]        prog_addr_o,
  input logic [PROG_W-1:0] prog_data_o,
  input logic              fuse_rd_en_o,
  input logic [IDX_W-1:0]  fuse_rd_addr_o,
  input logic              err_i
);
  p_rsp_follows_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> rsp_valid_o);
  p_no_spurious_rsp_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && req_ready_o) |=> !rsp_valid_o);
  p_ready_block_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !req_ready_o);
  p_prog_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_req_o && !prog_done_i) |=> (prog_req_o && $stable(prog_addr_o)));
  p_prog_data_stable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_req_o && !prog_done_i) |=> $stable(prog_data_o));
  p_no_launch_in_err_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(prog_req_o) |-> !$past(err_i));
  p_err_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_i && !(req_valid_i && req_ready_o && req_we_i && req_addr_i == 12'h008 && clr_err_bit_i))
    |=> err_i);
  p_reload_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fuse_rd_en_o |-> !prog_req_o);
  p_reload_range_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fuse_rd_en_o |-> (int'(fuse_rd_addr_o) < NUM_WORDS));
endmodule

bind fuse_ctl_regs fuse_ctl_regs_chk #(
  .NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W), .PROG_W(PROG_W)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
  .req_we_i(req_we_i), .req_addr_i(req_addr_i), .clr_err_bit_i(req_wdata_i[9]),
  .rsp_valid_o(rsp_valid_o), .prog_req_o(prog_req_o), .prog_done_i(prog_done_i),
  .prog_addr_o(prog_addr_o), .prog_data_o(prog_data_o), .fuse_rd_en_o(fuse_rd_en_o),
  .fuse_rd_addr_o(fuse_rd_addr_o), .err_i(err_q)
);

// File: tb/fuse_ctl_regs_tb_top.sv
`timescale 1ns/1ps
module fuse_ctl_regs_tb_top;
  localparam int NW = 16;
  localparam int BW = 4;
  localparam int IW = 4;
  localparam logic [31:0] POIS = 32'hBADA_BADA;
  localparam logic [NW-1:0] RLOCK = 16'h0010;
  localparam logic [NW-1:0] WLOCK = 16'h0300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic req_valid = 1'b0, req_we = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid, prog_req, fuse_rd_en;
  logic [31:0] rsp_rdata, timing;
  logic [7:0] prog_addr;
  logic [32*BW-1:0] prog_data;
  logic prog_done = 1'b0;
  logic [IW-1:0] fuse_rd_addr;
  logic [31:0] fuse_rd_data = '0;

  fuse_ctl_regs #(.NUM_WORDS(NW), .BANK_WORDS(BW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_we_i(req_we), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .rd_lock_i(RLOCK), .wr_lock_i(WLOCK),
    .timing_o(timing), .prog_req_o(prog_req), .prog_addr_o(prog_addr), .prog_data_o(prog_data),
    .prog_done_i(prog_done), .fuse_rd_en_o(fuse_rd_en), .fuse_rd_addr_o(fuse_rd_addr),
    .fuse_rd_data_i(fuse_rd_data)
  );

  logic [31:0] fuse [NW];
  logic [31:0] exp_fuse [NW];
  int eng_cnt = 0;
  int vectors = 0, fails = 0;
  bit done = 0;

  function automatic logic [31:0] init_word(int n);
    return (32'h0101_0101 * (n + 1)) ^ 32'hF000_0000;
  endfunction
  function automatic logic [31:0] lane_pat(int g, int k);
    return (32'h0000_0011 << (g * 4 + k)) ^ 32'h0F00_0000;
  endfunction

  // fuse array read port and programming engine models
  always @(posedge clk) begin
    if (fuse_rd_en) fuse_rd_data <= fuse[fuse_rd_addr];
    prog_done <= 1'b0;
    if (prog_req && !prog_done) begin
      if (eng_cnt == 20) begin
        for (int k = 0; k < BW; k++)
          if (int'(prog_addr) * BW + k < NW)
            fuse[int'(prog_addr) * BW + k] <= fuse[int'(prog_addr) * BW + k] | prog_data[32*k +: 32];
        prog_done <= 1'b1;
        eng_cnt <= 0;
      end else eng_cnt <= eng_cnt + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input bit we, input logic [11:0] a, input logic [31:0] d,
                      output logic [31:0] r);
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    r = rsp_rdata;
    check("R13 rsp_valid", {31'd0, rsp_valid}, 32'd1);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    logic [31:0] r;
    xfer(1'b1, a, d, r);
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] r);
    xfer(1'b0, a, 32'd0, r);
  endtask

  task automatic clr_err();
    wr(12'h008, 32'h0000_0200);
  endtask

  task automatic wait_idle();
    logic [31:0] r;
    for (int i = 0; i < 300; i++) begin
      rd(12'h000, r);
      if (!r[8]) break;
    end
  endtask

  function automatic logic [11:0] sh_addr(int n);
    return 12'h400 + 12'(n * 16);
  endfunction

  task automatic sweep_shadows(input string tag);
    logic [31:0] r;
    for (int n = 0; n < NW; n++) begin
      rd(sh_addr(n), r);
      if (RLOCK[n]) begin
        check({tag, " R7 poison"}, r, POIS);
        rd(12'h000, r);
        check({tag, " R7 error set"}, {31'd0, r[9]}, 32'd1);
        clr_err();
      end else check({tag, " shadow"}, r, exp_fuse[n]);
    end
  endtask

  initial begin
    logic [31:0] r;
    for (int n = 0; n < NW; n++) begin
      fuse[n] = init_word(n);
      exp_fuse[n] = init_word(n);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 prog_req", {31'd0, prog_req}, 32'd0);
    check("R1 fuse_rd_en", {31'd0, fuse_rd_en}, 32'd0);
    check("R1 ready", {31'd0, req_ready}, 32'd1);
    rd(12'h000, r); check("R1 ctrl", r, 32'd0);
    rd(sh_addr(0), r); check("R1 shadow0", r, 32'd0);
    rd(sh_addr(15), r); check("R1 shadow15", r, 32'd0);

    // R12 timing
    wr(12'h010, 32'h0123_4567);
    rd(12'h010, r); check("R12 readback", r, 32'h0123_4567);
    check("R12 timing_o", timing, 32'h0123_4567);

    // R11 aliases
    wr(12'h000, 32'h0000_005A);
    wr(12'h004, 32'h0000_0081);
    rd(12'h000, r); check("R11 set alias", r, 32'h0000_00DB);
    wr(12'h008, 32'h0000_000A);
    rd(12'h000, r); check("R11 clr alias", r, 32'h0000_00D1);
    wr(12'h000, 32'h0);

    // R9 reload with R10 rejected write during reload
    wr(12'h004, 32'h0000_0400);
    rd(12'h000, r);
    check("R9 reload bit", {31'd0, r[10]}, 32'd1);
    check("R9 busy bit", {31'd0, r[8]}, 32'd1);
    wr(sh_addr(1), 32'hDEAD_BEEF);
    rd(12'h000, r); check("R10 err on write in reload", {31'd0, r[9]}, 32'd1);
    wait_idle();
    rd(12'h000, r); check("R9 self clear", r & 32'h0000_0500, 32'd0);
    clr_err();
    rd(12'h000, r); check("R8 clear alias", {31'd0, r[9]}, 32'd0);
    sweep_shadows("R9 reload");

    // R8 error blocks everything
    rd(sh_addr(4), r); check("R7 locked read", r, POIS);
    rd(sh_addr(0), r); check("R8 read in error", r, POIS);
    wr(12'h004, 32'h0000_0400);
    rd(12'h000, r); check("R8 reload blocked", r & 32'h0000_0500, 32'd0);
    wr(12'h000, 32'h3E77_0000);
    wr(12'h020, 32'h1);
    check("R8 launch blocked", {31'd0, prog_req}, 32'd0);
    rd(12'h000, r); check("R8 ctrl in error", r, 32'h3E77_0200);
    clr_err();
    rd(12'h000, r); check("R8 cleared", r, 32'h3E77_0000);
    wr(12'h000, 32'h0);
    rd(sh_addr(0), r); check("R8 read after clear", r, exp_fuse[0]);

    // R10 shadow write sweep
    for (int n = 0; n < NW; n++) begin
      logic [31:0] w;
      w = 32'hC0DE_0000 | 32'(n);
      wr(sh_addr(n), w);
      if (WLOCK[n]) begin
        rd(12'h000, r); check("R10 err on locked write", {31'd0, r[9]}, 32'd1);
        clr_err();
      end
      rd(sh_addr(n), r);
      if (RLOCK[n]) begin
        check("R7 poison after write", r, POIS);
        clr_err();
      end else check("R10 shadow after write", r, WLOCK[n] ? exp_fuse[n] : w);
    end

    // R2 wrong key
    wr(12'h000, 32'h3E76_0000);
    wr(12'h020, 32'h5);
    check("R2 wrong key no launch", {31'd0, prog_req}, 32'd0);
    rd(12'h000, r); check("R2 key kept", r, 32'h3E76_0000);

    // R6 out of range group
    wr(12'h000, 32'h3E77_0004);
    wr(12'h020, 32'h5);
    check("R6 range no req", {31'd0, prog_req}, 32'd0);
    rd(12'h000, r); check("R6 range err no busy", r, 32'h0000_0204);
    clr_err();

    // R3 R4 R5 R6 program every group
    for (int g = 0; g < 4; g++) begin
      for (int k = 1; k < BW; k++) wr(12'h020 + 12'(k * 16), lane_pat(g, k));
      wr(12'h000, 32'h3E77_0000 | 32'(g));
      check("R5 no start before lane0", {31'd0, prog_req}, 32'd0);
      wr(12'h020, lane_pat(g, 0));
      if (WLOCK[g*4 +: 4] != 4'd0) begin
        check("R6 locked no req", {31'd0, prog_req}, 32'd0);
        rd(12'h000, r); check("R6 locked err no busy", r, 32'h0000_0200 | 32'(g));
        clr_err();
      end else begin
        check("R3 prog_req", {31'd0, prog_req}, 32'd1);
        rd(12'h000, r); check("R2 R3 busy key cleared", r, 32'h0000_0100 | 32'(g));
        wr(12'h000, 32'h0000_0003);
        check("R3 addr held", {24'd0, prog_addr}, 32'(g));
        wr(12'h020, 32'hFFFF_FFFF);
        check("R4 lane0 held", prog_data[31:0], lane_pat(g, 0));
        for (int k = 0; k < BW; k++)
          check("R5 lane map", prog_data[32*k +: 32], lane_pat(g, k));
        wait_idle();
        check("R3 done", {31'd0, prog_req}, 32'd0);
        for (int k = 0; k < BW; k++) exp_fuse[g*4+k] = exp_fuse[g*4+k] | lane_pat(g, k);
      end
    end

    wr(12'h004, 32'h0000_0400);
    wait_idle();
    sweep_shadows("R5 after program");

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule